// File: doc/BRIEF.md
# Byte-Lane Hamming Parity Generator for NAND Pages

This block computes a Hamming check code over blocks of data bytes on their way through a NAND data path. The code corrects any single flipped bit and detects two. Each bus write carries several bytes. The block splits them into lanes and folds all of them into its running state in one clock cycle. The most significant byte of the word counts as the lowest index. Over a block of `BLOCK_BYTES` bytes (256 by default) it builds line parity from the index of each byte. It builds column parity from the bit positions within the bytes.

Before each block the host pulses a clear strobe. It then streams the block through `data_i` with `wr_i` and reads `code_o` once `done_o` is high. The code word has an unused zero top byte, then two line-parity bytes, then one column-parity byte. Every parity bit is stored inverted, so an erased page of all-ones data gives an all-ones code. Writes that arrive after the block is complete are dropped until the next clear. Finding and fixing the faulty bit is left to the host.

Top module: `sm_ecc_gen`

## Requirements
- R1: After reset, or in the cycle after `clr_i` is high, `done_o` is 0 and `code_o` is 32'h00FF_FFFF.
- R2: The bytes of one `data_i` word take consecutive block indices, with bits [31:24] first. A word of 32'h0100_0000 written just after a clear gives 32'h00AA_AAAB. A word of 32'h0000_0001 written just after a clear gives 32'h00A5_AAAB.
- R3: Line parity bit LP(2k+1) toggles for each byte of odd bit-parity whose index has bit k set. LP(2k) toggles when index bit k is clear. LP0..LP7 sit inverted in `code_o[23:16]` and LP8..LP15 in `code_o[15:8]`, with bit n of each byte holding LP of the same weight.
- R4: Column parity is the parity over all bytes of bit positions p with p[j]==0 (CP(2j)) or p[j]==1 (CP(2j+1)), for j = 0..2. CP0..CP5 sit inverted in `code_o[7:2]`, with CP0 at bit 2.
- R5: `code_o[31:24]` is always 0 and `code_o[1:0]` is always 2'b11.
- R6: A block of all-0xFF bytes, and a block of all-0x00 bytes, both give 32'h00FF_FFFF.
- R7: `done_o` rises in the cycle after the write that carries byte 256, which is the 64th word at a 32-bit width. It stays low after 63 words. It falls only after a clear.
- R8: While `done_o` is high, writes leave `code_o` unchanged and `done_o` high.
- R9: When `clr_i` and `wr_i` are high in the same cycle, the clear wins and the word is discarded.
- R10: Cycles without `wr_i` leave `code_o` and `done_o` unchanged, so gaps between words do not change the result.
- R11: Flipping one data bit in a block changes exactly 11 bits of `code_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear strobe, issued before each block |
| wr_i | input | 1 | Data word valid |
| data_i | input | DATA_W | Data word, most significant byte first |
| code_o | output | 32 | Packed inverted parity code |
| done_o | output | 1 | Block complete |

## Verification
The bench builds the block with its defaults: a 32-bit data word (four lanes) and 256-byte blocks. With these values the per-lane index offsets, the counter reaching exactly 256 after 64 words, and the real three-byte code layout are all exercised. Single-word writes right after a clear expose the lane order. A pair of blocks that differ in one bit exercises the single-error signature.

// File: rtl/sm_ecc_pkg.sv
package sm_ecc_pkg;
  localparam int unsigned CODE_W = 32;

  // column parity from the XOR of all bytes
  function automatic logic [5:0] col_to_cp(input logic [7:0] c);
    logic [5:0] cp;
    cp[0] = c[0] ^ c[2] ^ c[4] ^ c[6];
    cp[1] = c[1] ^ c[3] ^ c[5] ^ c[7];
    cp[2] = c[0] ^ c[1] ^ c[4] ^ c[5];
    cp[3] = c[2] ^ c[3] ^ c[6] ^ c[7];
    cp[4] = ^c[3:0];
    cp[5] = ^c[7:4];
    return cp;
  endfunction
endpackage

// File: rtl/sm_ecc_cnt.sv
module sm_ecc_cnt #(
  parameter int unsigned BLOCK_BYTES = 256,
  parameter int unsigned LANES       = 4,
  localparam int unsigned IDX_W      = $clog2(BLOCK_BYTES),
  localparam int unsigned CNT_W      = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  output logic             acc_o,
  output logic [IDX_W-1:0] base_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == CNT_W'(BLOCK_BYTES));
  assign acc_o  = wr_i & ~clr_i & ~done_o;
  assign base_o = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (acc_o) cnt_q <= cnt_q + CNT_W'(LANES);
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BLOCK_BYTES));
  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> cnt_q == $past(cnt_q) + CNT_W'(LANES));
  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(clr_i));
endmodule

// File: rtl/sm_ecc_lane.sv
module sm_ecc_lane #(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned LP_W = 2 * IDX_W
) (
  input  logic [7:0]       byte_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [LP_W-1:0]  lp_o
);
  logic odd;
  assign odd = ^byte_i;

  always_comb begin
    for (int k = 0; k < IDX_W; k++) begin
      lp_o[2*k+1] = odd &  idx_i[k];
      lp_o[2*k]   = odd & ~idx_i[k];
    end
  end
endmodule

// File: rtl/sm_ecc_pack.sv
module sm_ecc_pack
  import sm_ecc_pkg::*;
#(
  parameter int unsigned LP_W = 16,
  localparam int unsigned NLB = LP_W / 8
) (
  input  logic [LP_W-1:0]   lp_i,
  input  logic [7:0]        col_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    code_o      = '0;
    code_o[7:0] = {~col_to_cp(col_i), 2'b11};
    // low line byte lands highest
    for (int b = 0; b < NLB; b++)
      code_o[8*(NLB-b) +: 8] = ~lp_i[8*b +: 8];
  end
endmodule

// File: rtl/sm_ecc_gen.sv
module sm_ecc_gen
  import sm_ecc_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BLOCK_BYTES = 256,
  localparam int unsigned LANES      = DATA_W / 8,
  localparam int unsigned IDX_W      = $clog2(BLOCK_BYTES),
  localparam int unsigned LP_W       = 2 * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [31:0]       code_o,
  output logic              done_o
);
  logic             acc;
  logic [IDX_W-1:0] base;
  logic [7:0]       lane_byte [LANES];
  logic [LP_W-1:0]  lane_lp   [LANES];
  logic [LP_W-1:0]  lp_sum, lp_q;
  logic [7:0]       col_sum, col_q;

  sm_ecc_cnt #(.BLOCK_BYTES(BLOCK_BYTES), .LANES(LANES)) u_cnt (
    .clk_i, .rst_ni, .clr_i, .wr_i,
    .acc_o(acc), .base_o(base), .done_o
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_byte[j] = data_i[DATA_W-1-8*j -: 8];
    sm_ecc_lane #(.IDX_W(IDX_W)) u_lane (
      .byte_i(lane_byte[j]),
      .idx_i (base + IDX_W'(j)),
      .lp_o  (lane_lp[j])
    );
  end

  always_comb begin
    lp_sum  = '0;
    col_sum = '0;
    for (int j = 0; j < LANES; j++) begin
      lp_sum  ^= lane_lp[j];
      col_sum ^= lane_byte[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q  <= '0;
      col_q <= '0;
    end else if (clr_i) begin
      lp_q  <= '0;
      col_q <= '0;
    end else if (acc) begin
      lp_q  <= lp_q ^ lp_sum;
      col_q <= col_q ^ col_sum;
    end
  end

  sm_ecc_pack #(.LP_W(LP_W)) u_pack (
    .lp_i(lp_q), .col_i(col_q), .code_o(code_o)
  );

  // R1
  clr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o && code_o[LP_W+7:0] == '1);
  // R8
  done_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> done_o && $stable(code_o));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !clr_i |=> $stable(code_o) && $stable(done_o));
endmodule

// File: tb/sim_sm_ecc_gen.sv
module sim_sm_ecc_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam logic [31:0] EMPTY = 32'h00FF_FFFF;

  logic        clk = 0, rst_n = 0, clr = 0, wr = 0;
  logic [31:0] data = '0;
  logic [31:0] code;
  logic        done;

  int errors = 0, checks = 0;
  logic [7:0]  blk [256];
  logic [31:0] exp_q [$];
  logic [31:0] last_code = '0;
  logic        done_d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_ecc_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .wr_i(wr),
    .data_i(data), .code_o(code), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_code();
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < 256; i++) begin
      if (^blk[i])
        for (int k = 0; k < 8; k++) lp[2*k + (i >> k & 1)] ^= 1'b1;
      for (int p = 0; p < 8; p++)
        if (blk[i][p])
          for (int j = 0; j < 3; j++) cp[2*j + (p >> j & 1)] ^= 1'b1;
    end
    return {8'h00, ~lp[7:0], ~lp[15:8], ~cp, 2'b11};
  endfunction

  function automatic logic [31:0] word_at(input int w);
    return {blk[4*w], blk[4*w+1], blk[4*w+2], blk[4*w+3]};
  endfunction

  task automatic pulse_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic wr_word(input logic [31:0] w);
    wr = 1; data = w;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic send_block(input int gap);
    exp_q.push_back(ref_code());
    pulse_clr();
    for (int w = 0; w < 64; w++) begin
      wr_word(word_at(w));
      repeat (gap) @(negedge clk);
    end
    @(negedge clk);
  endtask

  // monitor: compare code when a block completes
  always @(negedge clk) begin
    if (rst_n && done && !done_d) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected done", code, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(code == e, "R3/R4 block code", code, e);
      end
      last_code = code;
    end
    done_d = done;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, b, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(code == EMPTY && !done, "R1 reset", {code[31:1], done}, {EMPTY[31:1], 1'b0});
    rst_n = 1;
    @(negedge clk);

    // R2 lane order, hand values
    pulse_clr();
    wr_word(32'h0100_0000);
    check(code == 32'h00AA_AAAB, "R2 byte0", code, 32'h00AA_AAAB);
    pulse_clr();
    check(code == EMPTY && !done, "R1 clear", code, EMPTY);
    wr_word(32'h0000_0001);
    check(code == 32'h00A5_AAAB, "R2 byte3", code, 32'h00A5_AAAB);

    // R6 erased and zero blocks
    for (int i = 0; i < 256; i++) blk[i] = 8'hFF;
    send_block(0);
    check(last_code == EMPTY, "R6 erased", last_code, EMPTY);
    for (int i = 0; i < 256; i++) blk[i] = 8'h00;
    send_block(0);
    check(last_code == EMPTY, "R6 zeros", last_code, EMPTY);

    // R3 single odd byte at index 0x5A
    blk[8'h5A] = 8'h01;
    send_block(0);
    check(last_code == 32'h0066_99AB, "R3 lone byte", last_code, 32'h0066_99AB);

    // R8 writes after done are ignored
    held = code;
    wr_word(32'hDEAD_BEEF);
    wr_word(32'h1234_5678);
    check(code == held && done, "R8 post-done write", code, held);

    // R4 random blocks
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 256; i++) blk[i] = 8'($urandom());
      send_block(0);
    end
    check(last_code[31:24] == 8'h00 && last_code[1:0] == 2'b11, "R5 fixed fields", last_code, EMPTY);

    // R10 gaps between words
    for (int i = 0; i < 256; i++) blk[i] = 8'($urandom());
    send_block(2);
    a = ref_code();
    check(last_code == a, "R10 gapped block", last_code, a);

    // R11 single bit flip signature
    a = last_code;
    blk[37] ^= 8'h10;
    send_block(0);
    b = last_code;
    check($countones(a ^ b) == 11, "R11 flip distance", 32'($countones(a ^ b)), 32'd11);

    // R9 clear beats write
    @(negedge clk); clr = 1; wr = 1; data = 32'h0100_0000;
    @(negedge clk); clr = 0; wr = 0;
    check(code == EMPTY && !done, "R9 clear priority", code, EMPTY);

    // R7 done exactly after 64 words
    for (int i = 0; i < 256; i++) blk[i] = 8'($urandom());
    exp_q.push_back(ref_code());
    for (int w = 0; w < 63; w++) wr_word(word_at(w));
    check(!done, "R7 after 63 words", 32'(done), 32'd0);
    wr_word(word_at(63));
    check(done, "R7 after 64 words", 32'(done), 32'd1);
    @(negedge clk);
    check(done, "R7 done held", 32'(done), 32'd1);

    @(negedge clk);
    check(exp_q.size() == 0, "R7 all blocks completed", 32'(exp_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule